// File: doc/BRIEF.md
# Change-of-State Digital Input Controller

This peripheral samples forty-eight digital inputs, arranged as six byte-wide groups, and presents them to a host through a small window of eight byte registers. Each input passes through a synchroniser before any logic sees it. The block compares every group with its value one clock earlier. When any bit of a group toggles, in either direction, the block records that group as changed, provided software has allowed that group to report.

Software selects which groups may report by writing a group mask to the control address. When a permitted group changes, the block latches a per-group flag and raises a shared interrupt line. The flag stays set until software reads the status byte at the same address. That read returns the group flags and an active-low pending indication, then clears the flags and drops the interrupt. A change that lands in the same cycle as the read is not lost.

The bus is a plain synchronous byte interface. Read data is combinational from the address, and a read of the status address takes effect at the clock edge where the read strobe is high.

Top module: `cos_input_ctrl`

## Requirements
- R1: Input group n reads back at offset n for groups 0 to 2 and at offset n+1 for groups 3 to 5. Bit k of group n is input 8n+k. A level driven on an input is visible on the bus read two clock edges later.
- R2: Offset 3 reads 0x00, and bit 7 of the status byte at offset 7 always reads 0.
- R3: After reset the group mask is 0, no flag is set, the interrupt output is low and offset 7 reads 0x40. An input toggle after reset raises nothing until a mask is written.
- R4: A rising or falling transition on any input of a group whose mask bit is 1 sets status bit n of that group and drives the interrupt output high. This is visible after the third clock edge following the input change.
- R5: A transition in a group whose mask bit is 0 sets no flag and raises no interrupt.
- R6: A set flag stays set when the input returns to its earlier level, until it is cleared by a status read or by clearing the mask bit.
- R7: A status read (read strobe at offset 7) returns the flags as they stand, then clears them all and lowers the interrupt. A change that sets a flag in the same cycle as the read stays set after the read.
- R8: Writing the mask with a bit cleared clears that group's pending flag. Flags of groups still enabled are kept.
- R9: Writes to offsets 0 to 6 change neither the mask nor any flag.
- R10: Status bit 6 is 0 while the interrupt output is high and 1 while it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe, used to clear status on offset 7 |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current offset |
| din | input | 48 | Asynchronous digital inputs |
| irq_out | output | 1 | Interrupt, high while any flag is set |

## Verification
The hardest case to reach from the ports is a change that reaches the flag register in the very cycle a status read clears it. The bench toggles one input on a falling edge and counts two rising edges. It then raises the read strobe so that the read and the flag set share the third edge. It checks that the read byte shows no flag and that the flag is present afterwards. Sweeps over all forty-eight inputs in both directions, and over each group disabled alone, cover the detection and masking paths.

// File: rtl/cos_pkg.sv
package cos_pkg;
  localparam int PORT_W      = 8;
  localparam int NUM_PORTS   = 6;
  localparam int ADDR_W      = 3;
  localparam int IN_W        = PORT_W * NUM_PORTS;
  localparam int STATUS_OFS  = 7;
  localparam int RSVD_OFS    = 3;
  localparam int IRQ_FLAG_B  = 6;

  typedef logic [NUM_PORTS-1:0] grp_mask_t;
  typedef logic [PORT_W-1:0]    byte_t;
endpackage

// File: rtl/cos_sync.sv
module cos_sync #(
  parameter int W      = 48,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= '0;
      else        stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/cos_edge.sv
module cos_edge #(
  parameter int NUM_PORTS = 6,
  parameter int PORT_W    = 8,
  localparam int W        = NUM_PORTS * PORT_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [W-1:0]         cur,
  output logic [NUM_PORTS-1:0] chg
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= cur;
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_grp
    assign chg[p] = |(cur[p*PORT_W +: PORT_W] ^ prev_q[p*PORT_W +: PORT_W]);
  end
endmodule

// File: rtl/cos_status.sv
module cos_status #(
  parameter int NUM_PORTS = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PORTS-1:0] chg,
  input  logic                 wr_en,
  input  logic [NUM_PORTS-1:0] wdata_en,
  input  logic                 rd_clr,
  output logic [NUM_PORTS-1:0] status_q,
  output logic                 irq
);
  logic [NUM_PORTS-1:0] en_q, en_n, status_n, keep, setv;

  always_comb begin
    en_n     = wr_en ? wdata_en : en_q;
    keep     = rd_clr ? '0 : status_q;
    setv     = chg & en_q;
    status_n = (keep | setv) & en_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (wr_en) en_q <= en_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= status_n;
  end

  assign irq = |status_q;

  AST_ONLY_ENABLED: assert property (@(posedge clk) disable iff (!rst_n) (status_q & ~en_q) == '0); // R5
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (!rd_clr && !wr_en) |=> (($past(status_q) & ~status_q) == '0)); // R6
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (rd_clr && !wr_en && ((chg & en_q) == '0)) |=> (status_q == '0)); // R7
  AST_SET_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n) (!wr_en && ((chg & en_q) != '0)) |=> ((status_q & $past(chg & en_q)) == $past(chg & en_q))); // R4
  AST_DISABLE_DROPS: assert property (@(posedge clk) disable iff (!rst_n) wr_en |=> ((status_q & ~$past(wdata_en)) == '0)); // R8
endmodule

// File: rtl/cos_input_ctrl.sv
module cos_input_ctrl
  import cos_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [PORT_W-1:0] bus_wdata,
  output logic [PORT_W-1:0] bus_rdata,
  input  logic [IN_W-1:0]   din,
  output logic              irq_out
);
  logic [IN_W-1:0] sync_q;
  grp_mask_t       chg, status_q;
  logic            at_status, wr_en, rd_clr, irq;
  byte_t           port_val [NUM_PORTS];
  byte_t           stat_byte, rd_mux;
  logic [ADDR_W-1:0] idx;

  cos_sync #(.W(IN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(din), .q(sync_q));

  cos_edge #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)) u_edge (
    .clk(clk), .rst_n(rst_n), .cur(sync_q), .chg(chg));

  assign at_status = (bus_addr == ADDR_W'(STATUS_OFS));
  assign wr_en     = bus_wr && at_status;
  assign rd_clr    = bus_rd && at_status;

  cos_status #(.NUM_PORTS(NUM_PORTS)) u_status (
    .clk(clk), .rst_n(rst_n), .chg(chg), .wr_en(wr_en),
    .wdata_en(bus_wdata[NUM_PORTS-1:0]), .rd_clr(rd_clr),
    .status_q(status_q), .irq(irq));

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    assign port_val[p] = sync_q[p*PORT_W +: PORT_W];
  end

  always_comb begin
    stat_byte                  = '0;
    stat_byte[NUM_PORTS-1:0]   = status_q;
    stat_byte[IRQ_FLAG_B]      = ~irq;
    idx = (bus_addr < ADDR_W'(RSVD_OFS)) ? bus_addr : bus_addr - ADDR_W'(1);
    rd_mux = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (idx == ADDR_W'(p)) rd_mux = port_val[p];
    end
    if (at_status)                          bus_rdata = stat_byte;
    else if (bus_addr == ADDR_W'(RSVD_OFS)) bus_rdata = '0;
    else                                    bus_rdata = rd_mux;
  end

  assign irq_out = irq;

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (bus_addr == ADDR_W'(RSVD_OFS)) |-> (bus_rdata == '0)); // R2
  AST_IRQ_FLAG: assert property (@(posedge clk) disable iff (!rst_n) at_status |-> (bus_rdata[IRQ_FLAG_B] == !irq_out)); // R10
  AST_BIT7_ZERO: assert property (@(posedge clk) disable iff (!rst_n) at_status |-> (bus_rdata[7] == 1'b0)); // R2
endmodule

// File: tb/sim_cos_input_ctrl.sv
module sim_cos_input_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  bus_addr;
  logic        bus_wr, bus_rd;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata;
  logic [47:0] din;
  logic        irq_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  cos_input_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .din(din), .irq_out(irq_out));

  function automatic logic [2:0] ofs_of(int p);
    return (p < 3) ? 3'(p) : 3'(p + 1);
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic peek(logic [2:0] a, output logic [7:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic rd_clear(output logic [7:0] v);
    @(negedge clk);
    bus_addr = 3'd7; bus_rd = 1'b1;
    #1;
    v = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic toggle_wait(int b);
    @(negedge clk);
    din[b] = ~din[b];
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #1500000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    rst_n = 1'b0; bus_addr = '0; bus_wr = 0; bus_rd = 0; bus_wdata = '0; din = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R3 reset state
    peek(3'd7, v); chk("R3 status after reset", v, 8'h40);
    chk("R3 irq after reset", {7'd0, irq_out}, 8'h00);
    peek(3'd3, v); chk("R2 reserved offset", v, 8'h00);
    toggle_wait(5);
    peek(3'd7, v); chk("R3 no flag with reset mask", v, 8'h40);
    chk("R3 irq low with reset mask", {7'd0, irq_out}, 8'h00);
    toggle_wait(5);

    // R1 port read sweep, mask left at zero
    for (int k = 0; k < 5; k++) begin
      logic [7:0] pat;
      pat = (k == 0) ? 8'hA5 : (k == 1) ? 8'h5A : (k == 2) ? 8'hFF : (k == 3) ? 8'h00 : 8'h3C;
      @(negedge clk);
      for (int p = 0; p < 6; p++) din[p*8 +: 8] = pat ^ 8'(p * 8'h11);
      repeat (2) @(posedge clk);
      @(negedge clk);
      for (int p = 0; p < 6; p++) begin
        peek(ofs_of(p), v);
        chk("R1 port read", v, pat ^ 8'(p * 8'h11));
      end
      peek(3'd3, v); chk("R2 offset 3 with inputs live", v, 8'h00);
    end
    @(negedge clk) din = '0;
    repeat (4) @(posedge clk);

    // R4 R7 R10 full sweep, both directions
    wr(3'd7, 8'h3F);
    rd_clear(v);
    for (int b = 0; b < 48; b++) begin
      for (int dir = 0; dir < 2; dir++) begin
        toggle_wait(b);
        peek(3'd7, v);
        chk(dir == 0 ? "R4 rising edge flag" : "R4 falling edge flag", v, 8'(1 << (b / 8)));
        chk("R10 irq high while pending", {7'd0, irq_out}, 8'h01);
        rd_clear(v);
        chk("R7 read returns flags", v, 8'(1 << (b / 8)));
        peek(3'd7, v);
        chk("R7 flags cleared by read", v, 8'h40);
        chk("R7 irq released", {7'd0, irq_out}, 8'h00);
      end
    end

    // R5 each group disabled alone
    for (int p = 0; p < 6; p++) begin
      wr(3'd7, 8'h3F & ~8'(1 << p));
      toggle_wait(p * 8 + 3);
      peek(3'd7, v); chk("R5 disabled group no flag", v, 8'h40);
      chk("R5 disabled group no irq", {7'd0, irq_out}, 8'h00);
      toggle_wait(p * 8 + 3);
    end

    // R6 sticky after input returns
    wr(3'd7, 8'h3F);
    toggle_wait(20);
    toggle_wait(20);
    peek(3'd7, v); chk("R6 flag kept after input returns", v, 8'h04);
    rd_clear(v);

    // R7 change coinciding with read
    @(negedge clk);
    din[41] = ~din[41];
    repeat (2) @(posedge clk);
    @(negedge clk);
    bus_addr = 3'd7; bus_rd = 1'b1;
    #1 v = bus_rdata;
    chk("R7 read in same cycle as set", v, 8'h40);
    @(negedge clk);
    bus_rd = 1'b0;
    peek(3'd7, v); chk("R7 coincident change kept", v, 8'h20);
    rd_clear(v);

    // R8 clearing a mask bit drops its flag
    toggle_wait(9);
    toggle_wait(33);
    peek(3'd7, v); chk("R8 two flags pending", v, 8'h12);
    wr(3'd7, 8'h2F);
    peek(3'd7, v); chk("R8 group 4 flag dropped", v, 8'h02);
    chk("R8 irq still high", {7'd0, irq_out}, 8'h01);
    wr(3'd7, 8'h2D);
    peek(3'd7, v); chk("R8 all flags dropped", v, 8'h40);
    chk("R8 irq low", {7'd0, irq_out}, 8'h00);

    // R9 writes elsewhere ignored
    wr(3'd7, 8'h3F);
    toggle_wait(44);
    for (int a = 0; a < 7; a++) wr(3'(a), 8'h00);
    peek(3'd7, v); chk("R9 flag kept across other writes", v, 8'h20);
    rd_clear(v);
    toggle_wait(17);
    peek(3'd7, v); chk("R9 mask kept across other writes", v, 8'h04);
    peek(3'd2, v); chk("R9 port read unaffected by writes", v, 8'h02);
    rd_clear(v);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule